// File: doc/BRIEF.md
# Halfword-Pairing Host Bus Width Adapter

The adapter sits between an external host bus and an internal 32-bit register and FIFO access port. A strap input picks the host bus width. The strap is captured while reset is held and then frozen. In the wide mode, every host access passes straight through as one internal DWORD access. In the narrow mode, the host moves 16 bits at a time. The adapter then pairs two halfword accesses into one internal DWORD access.

In the narrow mode, a host write of one half is parked in a staging register. The internal write happens only when the opposite half of the same DWORD arrives, and the write data is the merge of both halves. A host read of a first half fetches the whole DWORD once and keeps it in a latch. The opposite half is then served from that latch, so both halves come from the same internal read.

The two halves may arrive in either order. A second access to the same half ends the pending pair without an internal access. A change of DWORD address also ends the pending pair. Internal port accesses are combinational in the host access cycle. Host read data and its lane enables appear one clock later.

Top module: `hbus_width_adapter`

## Requirements
- R1: While rst_n is low, `wide_mode` loads `width_strap` on every clock (1 = 32-bit host, 0 = 16-bit host). After reset it holds that value whatever the strap does.
- R2: In the wide mode, a host access passes through in its own cycle. A read raises `int_rd` and a write raises `int_wr` with `int_wdata = host_wdata`, both with `int_addr = host_addr[ADDR_W-1:2]`. The cycle after a read, `host_rdata` carries the full `int_rdata` of the access cycle, with both lane enables high.
- R3: In the narrow mode, `host_addr[1]` picks the half: 0 is bits 15:0, 1 is bits 31:16. A write to one half followed by a write to the opposite half of the same DWORD, in either order, raises `int_wr` only in the cycle of the second write. `int_wdata` then holds each half's `host_wdata[15:0]` in its lane.
- R4: In the narrow mode, a write to the same half as a pending write gives no internal write and clears the pending pair. The next write starts a new pair.
- R5: In the narrow mode, a read that starts a pair raises `int_rd` and returns the selected half of `int_rdata` on `host_rdata[15:0]` one cycle later. The following read of the opposite half of the same DWORD raises no `int_rd`. It returns the other half of the DWORD captured by the first read, even if `int_rdata` has changed since.
- R6: In the narrow mode, a read of the same half as a pending read raises no `int_rd` and clears the pending pair. The next read fetches a fresh DWORD.
- R7: In the narrow mode, an access whose `host_addr[ADDR_W-1:2]` differs from the pending pair's DWORD abandons that pair. It is treated as the first half of a new pair.
- R8: In the narrow mode, `host_oe_hi` is never high and `host_rdata[31:16]` is zero. In both modes, `host_oe_lo` is high exactly in the cycle after each host read access.
- R9: In the narrow mode, a read clears any pending write half, and a write clears any pending read half.
- R10: A host access needs `host_cs` high. With `host_cs` low, neither internal strobe rises, and a pending pair is kept across idle cycles. When `host_rd` and `host_wr` are both high, the access is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| width_strap | input | 1 | Bus width strap, captured during reset |
| wide_mode | output | 1 | Captured width: 1 = 32-bit host |
| host_cs | input | 1 | Host chip select, one cycle per access |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W-1 | Host address bits ADDR_W-1 down to 1 |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after a read |
| host_oe_lo | output | 1 | Drive enable for host data bits 15:0 |
| host_oe_hi | output | 1 | Drive enable for host data bits 31:16 |
| int_addr | output | ADDR_W-2 | Internal DWORD address |
| int_rd | output | 1 | Internal read strobe |
| int_wr | output | 1 | Internal write strobe |
| int_wdata | output | 32 | Internal write data |
| int_rdata | input | 32 | Internal read data, valid in the `int_rd` cycle |

## Verification
The bench builds the adapter with `ADDR_W = 4`, so the host sees only four DWORDs. With so few addresses, random traffic keeps producing same-DWORD pairs, same-half repeats and DWORD switches, alongside directed sequences for each pairing rule. The bench runs one reset with the strap low and one with it high, which covers both widths in a single run. The internal read data is randomised on every access, so a second half served from the wrong source shows up as a mismatch.

// File: rtl/hba_pkg.sv
package hba_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;

  typedef struct packed {
    logic live;
    logic hi;
  } pair_state_t;

  function automatic logic [HALF_W-1:0] pick_half(input logic [WORD_W-1:0] dw, input logic hi);
    return hi ? dw[WORD_W-1:HALF_W] : dw[HALF_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] join_halves(input logic [HALF_W-1:0] held,
                                                     input logic held_hi,
                                                     input logic [HALF_W-1:0] fresh);
    return held_hi ? {held, fresh} : {fresh, held};
  endfunction
endpackage

// File: rtl/hba_width_strap.sv
module hba_width_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_i,
  output logic wide_o
);
  logic wide_q;

  always_ff @(posedge clk) begin
    if (!rst_n) wide_q <= strap_i;
  end

  assign wide_o = wide_q;
endmodule

// File: rtl/hba_wr_merge.sv
module hba_wr_merge
  import hba_pkg::*;
#(
  parameter int DW_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_i,
  input  logic              wr_acc_i,
  input  logic              rd_acc_i,
  input  logic              hi_i,
  input  logic [DW_W-1:0]   dw_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              int_wr_o,
  output logic [WORD_W-1:0] int_wdata_o,
  output logic              pair_done_o,
  output logic              repeat_o
);
  pair_state_t       st_q;
  logic [DW_W-1:0]   dw_q;
  logic [HALF_W-1:0] stage_q;
  logic              match;

  assign match       = st_q.live && (dw_q == dw_i);
  assign pair_done_o = wr_acc_i && match && (hi_i != st_q.hi);
  assign repeat_o    = wr_acc_i && match && (hi_i == st_q.hi);
  assign int_wr_o    = wide_i ? wr_acc_i : pair_done_o;
  assign int_wdata_o = wide_i ? wdata_i : join_halves(stage_q, st_q.hi, wdata_i[HALF_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      dw_q    <= '0;
      stage_q <= '0;
    end else if (wr_acc_i && !wide_i) begin
      if (match) begin
        st_q.live <= 1'b0;
      end else begin
        st_q    <= '{live: 1'b1, hi: hi_i};
        dw_q    <= dw_i;
        stage_q <= wdata_i[HALF_W-1:0];
      end
    end else if (rd_acc_i) begin
      st_q.live <= 1'b0;
    end
  end
endmodule

// File: rtl/hba_rd_split.sv
module hba_rd_split
  import hba_pkg::*;
#(
  parameter int DW_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_i,
  input  logic              rd_acc_i,
  input  logic              wr_acc_i,
  input  logic              hi_i,
  input  logic [DW_W-1:0]   dw_i,
  input  logic [WORD_W-1:0] int_rdata_i,
  output logic              int_rd_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              oe_lo_o,
  output logic              oe_hi_o,
  output logic              fetch_o,
  output logic              repeat_o
);
  pair_state_t       st_q;
  logic [DW_W-1:0]   dw_q;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] rdata_q;
  logic              valid_q;
  logic              match;
  logic [HALF_W-1:0] half_out;

  assign match    = st_q.live && (dw_q == dw_i);
  assign repeat_o = rd_acc_i && match && (hi_i == st_q.hi);
  assign fetch_o  = rd_acc_i && !match;
  assign int_rd_o = fetch_o;
  assign half_out = pick_half(match ? hold_q : int_rdata_i, hi_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      dw_q    <= '0;
      hold_q  <= '0;
      rdata_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_acc_i;
      if (rd_acc_i) rdata_q <= wide_i ? int_rdata_i : {{HALF_W{1'b0}}, half_out};
      if (rd_acc_i && !wide_i) begin
        if (match) begin
          st_q.live <= 1'b0;
        end else begin
          st_q   <= '{live: 1'b1, hi: hi_i};
          dw_q   <= dw_i;
          hold_q <= int_rdata_i;
        end
      end else if (wr_acc_i) begin
        st_q.live <= 1'b0;
      end
    end
  end

  assign rdata_o = rdata_q;
  assign oe_lo_o = valid_q;
  assign oe_hi_o = valid_q && wide_i;
endmodule

// File: rtl/hbus_width_adapter.sv
module hbus_width_adapter #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              width_strap,
  output logic              wide_mode,
  input  logic              host_cs,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:1] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_oe_lo,
  output logic              host_oe_hi,
  output logic [ADDR_W-1:2] int_addr,
  output logic              int_rd,
  output logic              int_wr,
  output logic [31:0]       int_wdata,
  input  logic [31:0]       int_rdata
);
  localparam int DW_W = ADDR_W - 2;

  logic            wide;
  logic            acc_rd, acc_wr;
  logic [DW_W-1:0] dw_sel;
  logic            half_hi;
  logic            wr_pair_done, wr_repeat;
  logic            rd_fetch, rd_repeat;

  assign acc_rd  = host_cs && host_rd;
  assign acc_wr  = host_cs && host_wr && !host_rd;
  assign dw_sel  = host_addr[ADDR_W-1:2];
  assign half_hi = host_addr[1];

  hba_width_strap u_strap (
    .clk(clk), .rst_n(rst_n), .strap_i(width_strap), .wide_o(wide)
  );

  hba_wr_merge #(.DW_W(DW_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wide_i(wide),
    .wr_acc_i(acc_wr), .rd_acc_i(acc_rd), .hi_i(half_hi), .dw_i(dw_sel),
    .wdata_i(host_wdata), .int_wr_o(int_wr), .int_wdata_o(int_wdata),
    .pair_done_o(wr_pair_done), .repeat_o(wr_repeat)
  );

  hba_rd_split #(.DW_W(DW_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .wide_i(wide),
    .rd_acc_i(acc_rd), .wr_acc_i(acc_wr), .hi_i(half_hi), .dw_i(dw_sel),
    .int_rdata_i(int_rdata), .int_rd_o(int_rd), .rdata_o(host_rdata),
    .oe_lo_o(host_oe_lo), .oe_hi_o(host_oe_hi),
    .fetch_o(rd_fetch), .repeat_o(rd_repeat)
  );

  assign int_addr  = dw_sel;
  assign wide_mode = wide;
endmodule

// File: rtl/hba_checker.sv
module hba_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wide,
  input logic        host_cs,
  input logic        host_rd,
  input logic        host_wr,
  input logic        host_oe_lo,
  input logic        host_oe_hi,
  input logic [31:0] host_rdata,
  input logic        int_rd,
  input logic        int_wr,
  input logic        rd_fetch,
  input logic        rd_repeat,
  input logic        wr_pair_done,
  input logic        wr_repeat
);
  // R1
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(wide));

  // R2
  wide_read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && host_cs && host_rd) |-> int_rd);

  // R3
  narrow_write_paired_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && int_wr) |-> (wr_pair_done && host_cs && host_wr));

  // R4
  write_repeat_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_repeat |-> !int_wr);

  // R6
  read_repeat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_repeat |-> (!int_rd && !rd_fetch));

  // R8
  upper_lane_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> (!host_oe_hi && host_rdata[31:16] == 16'h0));

  // R8
  read_enable_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && host_rd) |=> host_oe_lo);

  // R10
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_cs |-> (!int_rd && !int_wr));
endmodule

bind hbus_width_adapter hba_checker u_hba_checker (
  .clk(clk), .rst_n(rst_n), .wide(wide),
  .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
  .host_oe_lo(host_oe_lo), .host_oe_hi(host_oe_hi), .host_rdata(host_rdata),
  .int_rd(int_rd), .int_wr(int_wr),
  .rd_fetch(rd_fetch), .rd_repeat(rd_repeat),
  .wr_pair_done(wr_pair_done), .wr_repeat(wr_repeat)
);

// File: tb/test_hbus_width_adapter.sv
`timescale 1ns/1ps
module test_hbus_width_adapter;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          width_strap = 1'b0;
  logic          wide_mode;
  logic          host_cs = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic [AW-1:1] host_addr = '0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;
  logic          host_oe_lo, host_oe_hi;
  logic [AW-1:2] int_addr;
  logic          int_rd, int_wr;
  logic [31:0]   int_wdata;
  logic [31:0]   int_rdata = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model state
  bit       m32;
  bit       wp, whi, rp, rhi;
  bit [1:0] wdw, rdw;
  bit [15:0] wstage;
  bit [31:0] rlatch;
  bit       w_cut, r_cut;

  always #4 clk = ~clk;

  hbus_width_adapter #(.ADDR_W(AW)) i_hbus_width_adapter (
    .clk(clk), .rst_n(rst_n), .width_strap(width_strap), .wide_mode(wide_mode),
    .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_oe_lo(host_oe_lo), .host_oe_hi(host_oe_hi),
    .int_addr(int_addr), .int_rd(int_rd), .int_wr(int_wr),
    .int_wdata(int_wdata), .int_rdata(int_rdata)
  );

  function automatic bit [15:0] bsel(bit [31:0] d, bit hi);
    return 16'((d >> (hi ? 16 : 0)) & 32'h0000_FFFF);
  endfunction

  function automatic bit [31:0] bmerge(bit [15:0] st, bit st_hi, bit [15:0] fr);
    return ({16'h0, st} << (st_hi ? 16 : 0)) | ({16'h0, fr} << (st_hi ? 0 : 16));
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(bit strap);
    host_cs = 0; host_rd = 0; host_wr = 0;
    width_strap = strap;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    m32 = strap; wp = 0; rp = 0; w_cut = 0; r_cut = 0;
    @(negedge clk);
    chk(wide_mode == strap, "R1", "mode after reset", 32'(wide_mode), 32'(strap));
    chk(!host_oe_lo && !host_oe_hi, "R8", "enables after reset", {host_oe_hi, host_oe_lo}, 0);
    chk(!int_rd && !int_wr, "R10", "strobes after reset", {int_rd, int_wr}, 0);
  endtask

  task automatic acc(bit cs, bit rd, bit wr, bit [2:0] a, bit [31:0] wd);
    bit ar, aw, hi, e_rd, e_wr, full;
    bit [1:0] dw;
    bit [31:0] e_wd, e_rdata;
    string tag;
    host_cs = cs; host_rd = rd; host_wr = wr; host_addr = a; host_wdata = wd;
    int_rdata = $urandom;
    ar = cs && rd; aw = cs && wr && !rd;
    dw = a[2:1]; hi = a[0];
    e_rd = 0; e_wr = 0; e_wd = 0; e_rdata = 0; full = 1;
    tag = "R10";
    if (m32) begin
      e_rd = ar; e_wr = aw; e_wd = wd; e_rdata = int_rdata;
      if (ar || aw) tag = "R2";
    end else if (ar) begin
      if (wp) r_cut = 0;
      if (wp) begin wp = 0; w_cut = 1; end
      if (rp && rdw == dw) begin
        if (rhi != hi) begin tag = "R5"; e_rdata = {16'h0, bsel(rlatch, hi)}; end
        else begin tag = "R6"; full = 0; end
        rp = 0;
      end else begin
        tag = rp ? "R7" : (r_cut ? "R9" : "R5");
        e_rd = 1; e_rdata = {16'h0, bsel(int_rdata, hi)};
        rlatch = int_rdata; rp = 1; rhi = hi; rdw = dw;
      end
      r_cut = 0;
    end else if (aw) begin
      if (rp) begin rp = 0; r_cut = 1; end
      if (wp && wdw == dw) begin
        if (whi != hi) begin tag = "R3"; e_wr = 1; e_wd = bmerge(wstage, whi, wd[15:0]); end
        else tag = "R4";
        wp = 0;
      end else begin
        tag = wp ? "R7" : (w_cut ? "R9" : "R3");
        wp = 1; whi = hi; wdw = dw; wstage = wd[15:0];
      end
      w_cut = 0;
    end
    #1;
    chk(int_rd == e_rd, tag, "int_rd", 32'(int_rd), 32'(e_rd));
    chk(int_wr == e_wr, tag, "int_wr", 32'(int_wr), 32'(e_wr));
    if (e_wr) chk(int_wdata == e_wd, tag, "int_wdata", int_wdata, e_wd);
    if (e_rd || e_wr) chk(int_addr == dw, tag, "int_addr", 32'(int_addr), 32'(dw));
    @(posedge clk);
    @(negedge clk);
    host_cs = 0; host_rd = 0; host_wr = 0;
    chk(host_oe_lo == ar, "R8", "host_oe_lo", 32'(host_oe_lo), 32'(ar));
    chk(host_oe_hi == (ar && m32), m32 ? "R2" : "R8", "host_oe_hi", 32'(host_oe_hi), 32'(ar && m32));
    if (ar) begin
      if (full) chk(host_rdata == e_rdata, tag, "host_rdata", host_rdata, e_rdata);
      else chk(host_rdata[31:16] == 16'h0, "R8", "upper rdata", host_rdata, {16'h0, host_rdata[15:0]});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset(1'b0);
    width_strap = 1'b1;
    @(negedge clk);
    chk(wide_mode == 1'b0, "R1", "mode held after strap change", 32'(wide_mode), 0);
    // R3 pairs in both orders
    acc(1, 0, 1, 3'b000, 32'h1111_AAAA);
    acc(1, 0, 1, 3'b001, 32'h2222_BBBB);
    acc(1, 0, 1, 3'b011, 32'h3333_CCCC);
    acc(1, 0, 1, 3'b010, 32'h4444_DDDD);
    // R4 same-half repeat, then a new pair
    acc(1, 0, 1, 3'b100, 32'h0000_1234);
    acc(1, 0, 1, 3'b100, 32'h0000_5678);
    acc(1, 0, 1, 3'b101, 32'h0000_9ABC);
    acc(1, 0, 1, 3'b100, 32'h0000_DEF0);
    // R7 DWORD change
    acc(1, 0, 1, 3'b010, 32'h0000_0101);
    acc(1, 0, 1, 3'b101, 32'h0000_0202);
    acc(1, 0, 1, 3'b100, 32'h0000_0303);
    // R5 read pair, R6 repeat
    acc(1, 1, 0, 3'b000, 0);
    acc(1, 1, 0, 3'b001, 0);
    acc(1, 1, 0, 3'b110, 0);
    acc(1, 1, 0, 3'b110, 0);
    acc(1, 1, 0, 3'b111, 0);
    acc(1, 1, 0, 3'b110, 0);
    // R9 cross-direction clear
    acc(1, 0, 1, 3'b000, 32'h0000_7777);
    acc(1, 1, 0, 3'b010, 0);
    acc(1, 0, 1, 3'b001, 32'h0000_8888);
    acc(1, 0, 1, 3'b000, 32'h0000_9999);
    // R10 idle keeps pair, read wins when both strobes
    acc(1, 0, 1, 3'b010, 32'h0000_AAAA);
    acc(0, 0, 1, 3'b011, 32'h0000_BBBB);
    acc(0, 0, 0, 3'b000, 0);
    acc(1, 0, 1, 3'b011, 32'h0000_CCCC);
    acc(1, 1, 1, 3'b100, 32'h0000_DDDD);
    for (int i = 0; i < 300; i++) begin
      bit [3:0] r = 4'($urandom);
      acc(r != 0, r[0], !r[0] || (r == 4'hF), 3'($urandom), $urandom);
    end
    do_reset(1'b1);
    width_strap = 1'b0;
    @(negedge clk);
    chk(wide_mode == 1'b1, "R1", "wide mode held", 32'(wide_mode), 1);
    acc(1, 1, 0, 3'b001, 0);
    acc(1, 0, 1, 3'b001, 32'hCAFE_F00D);
    for (int i = 0; i < 200; i++) begin
      bit [3:0] r = 4'($urandom);
      acc(r != 0, r[0], !r[0], 3'($urandom), $urandom);
    end
    finish_run();
  end
endmodule